// File: doc/BRIEF.md
# Control Register Mode Tracker

This block keeps the paging and protection control words of a processor core, together with the long-mode active state and the address-line-20 gate. Writes arrive on separate strobe-plus-data ports for the two control words and for the A20 state. The block applies the side effects that a write implies: it forces fixed bits, masks capability-gated bits, enters or leaves long mode, and issues a one-cycle translation-cache flush request whenever a bit that affects address translation changes.

The hidden mode flags that the rest of the core decodes are derived from the stored state and driven as individual outputs. These are protected mode, forced segment-base add, coprocessor monitor, emulation and task-switched, long mode active, 64-bit code segment and extended-state save enable. When long mode is left, a one-cycle pulse tells the fetch unit to cut the instruction pointer to 32 bits. The long-mode enable request and the SSE capability come in as level inputs. The 64-bit code-segment flag is loaded by the segment logic through its own strobe.

Top module: `cr_mode_tracker`

## Requirements
- R1: After reset the mode-control word is 0x60000010, the extension control word is 0, the A20 mask is all ones, long mode and the 64-bit code flag are 0, and neither pulse output is high.
- R2: A mode-control write that is accepted appears on `cr0_o` in the cycle after its strobe, with bit 4 always stored as 1.
- R3: An accepted mode-control write that changes bit 31 (paging), bit 16 (write protect) or bit 0 (protection enable) raises `tlb_flush_o` for exactly one cycle after the strobe. A change to other bits only raises no flush.
- R4: A write that sets bit 31 while it was clear and `lme_i` is 1 sets `lma_o` when bit 5 (address extension) of the extension word is set. When bit 5 is clear, the whole write is dropped: the word is unchanged, there is no flush, and `lma_o` stays 0.
- R5: A write that clears bit 31 while `lma_o` is 1 clears `lma_o` and `cs64_o` and pulses `eip_trunc_o` for one cycle. Clearing bit 31 outside long mode gives no such pulse.
- R6: `pe_o` equals stored bit 0 and `addseg_o` is 1 whenever `pe_o` is 0. `mp_o`, `em_o` and `ts_o` equal stored bits 1, 2 and 3.
- R7: An extension-word write that changes bit 4 (large pages), bit 5 (address extension) or bit 7 (global pages) raises a one-cycle flush. Other bit changes raise none.
- R8: Bit 9 (extended-state save enable) of an extension-word write is stored as 0 when `sse_cap_i` is 0, and `osfxsr_o` follows the stored bit 9.
- R9: Writing an A20 state that differs from the current one raises a one-cycle flush, and the mask becomes all ones except bit 20, which equals the new state.
- R10: Writing an A20 state equal to the current one causes no flush and leaves the mask unchanged.
- R11: A `cs64_we_i` strobe loads `cs64_i` into `cs64_o` only while long mode is active; outside long mode it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cr0_we_i | input | 1 | Mode-control word write strobe |
| cr0_wdata_i | input | 32 | Mode-control write data |
| cr4_we_i | input | 1 | Extension control word write strobe |
| cr4_wdata_i | input | 32 | Extension control write data |
| a20_we_i | input | 1 | A20 state write strobe |
| a20_i | input | 1 | New A20 state |
| cs64_we_i | input | 1 | 64-bit code flag load strobe |
| cs64_i | input | 1 | 64-bit code flag value |
| lme_i | input | 1 | Long-mode enable request level |
| sse_cap_i | input | 1 | SSE capability present |
| cr0_o | output | 32 | Stored mode-control word |
| cr4_o | output | 32 | Stored extension control word |
| a20_mask_o | output | 32 | Address mask from the A20 state |
| lma_o | output | 1 | Long mode active |
| cs64_o | output | 1 | 64-bit code segment flag |
| pe_o | output | 1 | Hidden protection-enable flag |
| addseg_o | output | 1 | Hidden forced segment-base add flag |
| mp_o | output | 1 | Hidden coprocessor monitor flag |
| em_o | output | 1 | Hidden emulation flag |
| ts_o | output | 1 | Hidden task-switched flag |
| osfxsr_o | output | 1 | Hidden extended-state save enable flag |
| eip_trunc_o | output | 1 | One-cycle pulse: cut instruction pointer to 32 bits |
| tlb_flush_o | output | 1 | One-cycle translation-cache flush request |

## Verification
The bench tries to enter long mode with address extension off. A design that does not drop that write would store paging on, flush, or raise long mode without the tables to support it. The bench checks that writes touching only the coprocessor bits or bit 9 cause no flush, which catches a design that flushes on any change, and it writes an unchanged A20 state, where a naive design would flush anyway. It also checks that the flush and truncate pulses fall after one cycle, that bit 9 is dropped without SSE capability, and that a 64-bit code load outside long mode is ignored. A design that got any of these wrong would show a wrong bit on the ports in the cycle after the strobe.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int unsigned XLEN = 32;

  // mode-control word bit positions
  localparam int unsigned B_PE = 0;
  localparam int unsigned B_MP = 1;
  localparam int unsigned B_EM = 2;
  localparam int unsigned B_TS = 3;
  localparam int unsigned B_ET = 4;
  localparam int unsigned B_WP = 16;
  localparam int unsigned B_PG = 31;

  // extension word bit positions
  localparam int unsigned B_PSE    = 4;
  localparam int unsigned B_PAE    = 5;
  localparam int unsigned B_PGE    = 7;
  localparam int unsigned B_OSFXSR = 9;

  localparam logic [XLEN-1:0] CR0_RESET = 32'h6000_0010;
  localparam logic [XLEN-1:0] CR4_RESET = '0;

  localparam logic [XLEN-1:0] CR0_FLUSH_MASK =
    (XLEN'(1) << B_PG) | (XLEN'(1) << B_WP) | (XLEN'(1) << B_PE);
  localparam logic [XLEN-1:0] CR4_FLUSH_MASK =
    (XLEN'(1) << B_PGE) | (XLEN'(1) << B_PAE) | (XLEN'(1) << B_PSE);
endpackage

// File: rtl/cr0_unit.sv
module cr0_unit
  import cr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            lme_i,
  input  logic            pae_i,
  input  logic            cs64_we_i,
  input  logic            cs64_i,
  output logic [XLEN-1:0] cr0_o,
  output logic            lma_o,
  output logic            cs64_o,
  output logic            flush_req_o,
  output logic            leave_o
);
  logic [XLEN-1:0] cr0_q, wr_val;
  logic            lma_q, cs64_q;
  logic            pg_rise, pg_fall, enter, reject, accept;

  always_comb begin
    wr_val       = wdata_i;
    wr_val[B_ET] = 1'b1;
  end

  assign pg_rise = we_i & ~cr0_q[B_PG] &  wr_val[B_PG];
  assign pg_fall = we_i &  cr0_q[B_PG] & ~wr_val[B_PG];
  assign enter   = pg_rise & lme_i;
  assign reject  = enter & ~pae_i;
  assign accept  = we_i & ~reject;
  assign leave_o = pg_fall & lma_q;
  assign flush_req_o = accept & (|((wr_val ^ cr0_q) & CR0_FLUSH_MASK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr0_q  <= CR0_RESET;
      lma_q  <= 1'b0;
      cs64_q <= 1'b0;
    end else begin
      if (accept) cr0_q <= wr_val;
      if (enter && pae_i) lma_q <= 1'b1;
      else if (leave_o)   lma_q <= 1'b0;
      if (leave_o)                  cs64_q <= 1'b0;
      else if (cs64_we_i && lma_q)  cs64_q <= cs64_i;
    end
  end

  assign cr0_o  = cr0_q;
  assign lma_o  = lma_q;
  assign cs64_o = cs64_q;

  // R4: entry without address extension leaves everything as it was
  p_reject_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && lme_i && !pae_i && !cr0_q[B_PG] && wdata_i[B_PG])
      |=> (cr0_q == $past(cr0_q)) && !lma_q);

  // R4: long mode never active without paging
  p_lma_needs_pg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lma_q |-> cr0_q[B_PG]);

  // R5: leaving paging in long mode clears both mode flags
  p_exit_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && cr0_q[B_PG] && !wdata_i[B_PG] && lma_q) |=> !lma_q && !cs64_q);

  // R11: 64-bit code flag only set inside long mode
  p_cs64_in_lm_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs64_q) |-> lma_q);
endmodule

// File: rtl/cr4_unit.sv
module cr4_unit
  import cr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            sse_cap_i,
  output logic [XLEN-1:0] cr4_o,
  output logic            flush_req_o
);
  logic [XLEN-1:0] cr4_q, wr_val;

  always_comb begin
    wr_val = wdata_i;
    if (!sse_cap_i) wr_val[B_OSFXSR] = 1'b0;
  end

  assign flush_req_o = we_i & (|((wr_val ^ cr4_q) & CR4_FLUSH_MASK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cr4_q <= CR4_RESET;
    else if (we_i) cr4_q <= wr_val;
  end

  assign cr4_o = cr4_q;

  // R8: without SSE capability the save-enable bit never lands
  p_osfxsr_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sse_cap_i) |=> !cr4_q[B_OSFXSR]);
endmodule

// File: rtl/a20_unit.sv
module a20_unit
  import cr_pkg::*;
#(
  parameter int unsigned A20_BIT = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            a20_i,
  output logic [XLEN-1:0] mask_o,
  output logic            flush_req_o
);
  logic a20_q;

  assign flush_req_o = we_i & (a20_i != a20_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          a20_q <= 1'b1;
    else if (flush_req_o) a20_q <= a20_i;
  end

  for (genvar i = 0; i < XLEN; i++) begin : g_mask
    if (i == A20_BIT) begin : g_gate
      assign mask_o[i] = a20_q;
    end else begin : g_pass
      assign mask_o[i] = 1'b1;
    end
  end

  // R10: rewriting the same state changes nothing
  p_a20_same_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (a20_i == a20_q)) |=> $stable(mask_o));
endmodule

// File: rtl/cr_mode_tracker.sv
module cr_mode_tracker
  import cr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cr0_we_i,
  input  logic [XLEN-1:0] cr0_wdata_i,
  input  logic            cr4_we_i,
  input  logic [XLEN-1:0] cr4_wdata_i,
  input  logic            a20_we_i,
  input  logic            a20_i,
  input  logic            cs64_we_i,
  input  logic            cs64_i,
  input  logic            lme_i,
  input  logic            sse_cap_i,
  output logic [XLEN-1:0] cr0_o,
  output logic [XLEN-1:0] cr4_o,
  output logic [XLEN-1:0] a20_mask_o,
  output logic            lma_o,
  output logic            cs64_o,
  output logic            pe_o,
  output logic            addseg_o,
  output logic            mp_o,
  output logic            em_o,
  output logic            ts_o,
  output logic            osfxsr_o,
  output logic            eip_trunc_o,
  output logic            tlb_flush_o
);
  logic cr0_flush, cr4_flush, a20_flush, leave;
  logic flush_q, trunc_q;

  cr0_unit u_cr0 (
    .clk_i, .rst_ni,
    .we_i        (cr0_we_i),
    .wdata_i     (cr0_wdata_i),
    .lme_i,
    .pae_i       (cr4_o[B_PAE]),   // pre-write extension word
    .cs64_we_i, .cs64_i,
    .cr0_o, .lma_o, .cs64_o,
    .flush_req_o (cr0_flush),
    .leave_o     (leave)
  );

  cr4_unit u_cr4 (
    .clk_i, .rst_ni,
    .we_i        (cr4_we_i),
    .wdata_i     (cr4_wdata_i),
    .sse_cap_i,
    .cr4_o,
    .flush_req_o (cr4_flush)
  );

  a20_unit #(.A20_BIT(20)) u_a20 (
    .clk_i, .rst_ni,
    .we_i        (a20_we_i),
    .a20_i,
    .mask_o      (a20_mask_o),
    .flush_req_o (a20_flush)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q <= 1'b0;
      trunc_q <= 1'b0;
    end else begin
      flush_q <= cr0_flush | cr4_flush | a20_flush;
      trunc_q <= leave;
    end
  end

  assign tlb_flush_o = flush_q;
  assign eip_trunc_o = trunc_q;
  assign pe_o        = cr0_o[B_PE];
  assign addseg_o    = ~cr0_o[B_PE];
  assign mp_o        = cr0_o[B_MP];
  assign em_o        = cr0_o[B_EM];
  assign ts_o        = cr0_o[B_TS];
  assign osfxsr_o    = cr4_o[B_OSFXSR];

  // R3: a flush always traces back to a write strobe one cycle earlier
  p_flush_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_flush_o |-> $past(cr0_we_i || cr4_we_i || a20_we_i));

  // R5: truncate pulse only when long mode has just been left
  p_trunc_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eip_trunc_o |-> (!lma_o && $past(lma_o)));

  // R9: a changed mask is always accompanied by a flush
  p_a20_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(a20_mask_o) |-> tlb_flush_o);

  // R6: real mode always adds segment bases
  p_addseg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pe_o |-> addseg_o);
endmodule

// File: tb/cr_mode_tracker_bench.sv
module cr_mode_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cr0_we = 0, cr4_we = 0, a20_we = 0, cs64_we = 0;
  logic [31:0] cr0_d = '0, cr4_d = '0;
  logic        a20_d = 0, cs64_d = 0, lme = 0, sse = 1;
  logic [31:0] cr0_o, cr4_o, mask_o;
  logic        lma_o, cs64_o, pe_o, addseg_o, mp_o, em_o, ts_o, osfxsr_o, trunc_o, flush_o;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cr_mode_tracker u_cr_mode_tracker (
    .clk_i(clk), .rst_ni(rst_n),
    .cr0_we_i(cr0_we), .cr0_wdata_i(cr0_d),
    .cr4_we_i(cr4_we), .cr4_wdata_i(cr4_d),
    .a20_we_i(a20_we), .a20_i(a20_d),
    .cs64_we_i(cs64_we), .cs64_i(cs64_d),
    .lme_i(lme), .sse_cap_i(sse),
    .cr0_o(cr0_o), .cr4_o(cr4_o), .a20_mask_o(mask_o),
    .lma_o(lma_o), .cs64_o(cs64_o), .pe_o(pe_o), .addseg_o(addseg_o),
    .mp_o(mp_o), .em_o(em_o), .ts_o(ts_o), .osfxsr_o(osfxsr_o),
    .eip_trunc_o(trunc_o), .tlb_flush_o(flush_o)
  );

  typedef struct {
    logic [63:0] tag;
    logic [31:0] cr0, cr4, mask;
    logic        lma, cs64, trunc, flush;
  } exp_t;

  exp_t sb_q[$];

  // reference state built from the requirements
  logic [31:0] m_cr0 = 32'h6000_0010, m_cr4 = '0;
  logic        m_a20 = 1, m_lma = 0, m_cs64 = 0;

  task automatic chk(input logic [63:0] tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: compare everything due after the last edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tag, "cr0", cr0_o, e.cr0);
      chk(e.tag, "cr4", cr4_o, e.cr4);
      chk(e.tag, "a20_mask", mask_o, e.mask);
      chk(e.tag, "lma", 32'(lma_o), 32'(e.lma));
      chk(e.tag, "cs64", 32'(cs64_o), 32'(e.cs64));
      chk(e.tag, "flush", 32'(flush_o), 32'(e.flush));
      chk(e.tag, "eip_trunc", 32'(trunc_o), 32'(e.trunc));
      chk(e.tag, "hidden_flags",
          {26'd0, pe_o, addseg_o, mp_o, em_o, ts_o, osfxsr_o},
          {26'd0, e.cr0[0], ~e.cr0[0], e.cr0[1], e.cr0[2], e.cr0[3], e.cr4[9]});
    end
  end

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(input logic [63:0] tag,
                      input logic w0, input logic [31:0] d0,
                      input logic w4, input logic [31:0] d4,
                      input logic wa, input logic da,
                      input logic wc, input logic dc);
    exp_t e;
    logic [31:0] v;
    logic fl = 0, tr = 0, n_lma = m_lma, n_cs64 = m_cs64;
    logic [31:0] n_cr0 = m_cr0, n_cr4 = m_cr4;
    logic n_a20 = m_a20;
    @(negedge clk);
    cr0_we = w0; cr0_d = d0; cr4_we = w4; cr4_d = d4;
    a20_we = wa; a20_d = da; cs64_we = wc; cs64_d = dc;
    if (wc && m_lma) n_cs64 = dc;
    if (w0) begin
      v = d0 | 32'h10;
      if (!m_cr0[31] && v[31] && lme && !m_cr4[5]) begin
        // rejected entry: no change
      end else begin
        if (!m_cr0[31] && v[31] && lme) n_lma = 1;
        if (m_cr0[31] && !v[31] && m_lma) begin
          n_lma = 0; n_cs64 = 0; tr = 1;
        end
        if (((v ^ m_cr0) & 32'h8001_0001) != 0) fl = 1;
        n_cr0 = v;
      end
    end
    if (w4) begin
      v = d4;
      if (!sse) v[9] = 1'b0;
      if (((v ^ m_cr4) & 32'h0000_00B0) != 0) fl = 1;
      n_cr4 = v;
    end
    if (wa && da != m_a20) begin
      fl = 1; n_a20 = da;
    end
    m_cr0 = n_cr0; m_cr4 = n_cr4; m_a20 = n_a20; m_lma = n_lma; m_cs64 = n_cs64;
    @(posedge clk);
    #1;
    e.tag = tag; e.cr0 = m_cr0; e.cr4 = m_cr4;
    e.mask = 32'hFFEF_FFFF | (32'(m_a20) << 20);
    e.lma = m_lma; e.cs64 = m_cs64; e.trunc = tr; e.flush = fl;
    sb_q.push_back(e);
  endtask

  task automatic idle(input logic [63:0] tag);
    step(tag, 0, '0, 0, '0, 0, 0, 0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1");                                      // reset state
        step("R2_R3", 1, 32'h0000_0001, 0, '0, 0, 0, 0, 0); // ET forced, PE flush
        idle("R3");                                      // flush lasts one cycle
        step("R6", 1, 32'h0000_000F, 0, '0, 0, 0, 0, 0);    // coprocessor bits, no flush
        step("R3", 1, 32'h0001_000F, 0, '0, 0, 0, 0, 0);    // WP flush
        step("R3", 1, 32'h8001_000F, 0, '0, 0, 0, 0, 0);    // PG on without lme
        step("R5", 1, 32'h0001_000F, 0, '0, 0, 0, 0, 0);    // PG off, not long mode
        step("R7", 0, '0, 1, 32'h0000_0020, 0, 0, 0, 0);    // PAE flush
        step("R8", 0, '0, 1, 32'h0000_0220, 0, 0, 0, 0);    // save enable, no flush
        sse = 0;
        step("R8", 0, '0, 1, 32'h0000_0220, 0, 0, 0, 0);    // masked off
        sse = 1;
        step("R7", 0, '0, 1, 32'h0000_0000, 0, 0, 0, 0);    // PAE clear, flush
        lme = 1;
        step("R4", 1, 32'h8001_000F, 0, '0, 0, 0, 0, 0);    // rejected entry
        step("R11", 0, '0, 0, '0, 0, 0, 1, 1);              // ignored outside long mode
        step("R7", 0, '0, 1, 32'h0000_00B0, 0, 0, 0, 0);    // PAE+PGE+PSE
        step("R4", 1, 32'h8001_000F, 0, '0, 0, 0, 0, 0);    // long mode entry
        step("R11", 0, '0, 0, '0, 0, 0, 1, 1);              // 64-bit code load
        step("R5", 1, 32'h0001_000F, 0, '0, 0, 0, 0, 0);    // exit, truncate
        idle("R5");                                      // pulses end
        lme = 0;
        step("R9", 0, '0, 0, '0, 1, 0, 0, 0);               // gate A20 off
        step("R10", 0, '0, 0, '0, 1, 0, 0, 0);              // same state
        step("R9", 0, '0, 0, '0, 1, 1, 0, 0);               // back on
        step("R10", 0, '0, 0, '0, 1, 1, 0, 0);
        step("R3", 1, 32'h0001_000E, 1, 32'h0000_00B0, 0, 0, 0, 0); // PE off
        idle("R6");
        @(negedge clk);
        @(negedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule